// File: doc/BRIEF.md
# Dual-mode programmable frequency generator bank

This block holds six independent frequency generators whose settings live in two 32-bit control words, three generators per word. Each generator picks one of three PLL source clocks, divides it by a programmable integer and can be gated off. The control words are written and read over a simple single-cycle register bus.

The whole bank runs on one system clock. Each PLL source reaches the bank as a one-cycle qualifier strobe on `src_tick_i`, and one strobe stands for one source clock edge. Each generator drives a divided level on `gen_clk_o` and a one-cycle strobe on `gen_tick_o` that marks the first system cycle of every output period.

An elaboration-time parameter picks how each generator's 10-bit slice is decoded. Legacy decoding has an enable bit and a two-way source select, and the divisor is always even. Extended decoding has a three-way source select whose zero code means off. In extended decoding a per-word scale bit switches the divisor between even values and unit steps.

Top module: `fgen_bank`

## Requirements
- R1: Two control words at addresses 0 and 1. Generator g uses the 10-bit slice starting at bit 10*(g mod 3) of word g/3. Bits 30:0 are stored and read back on `rdata_o` for the word at `addr_i` in the same cycle. Bit 31 always reads 0.
- R2: Slice bits [9:2] hold a divide code N. With even division the divisor is D = (N+1)*2, which covers 2 up to 512.
- R3: In extended decoding, bit 30 of a word is the scale bit for its three generators. When it is 0 the divisor is (N+1)*2. When it is 1 the divisor is N+1, which covers 1 up to 256.
- R4: In legacy decoding, slice bit 1 enables the generator. Slice bit 0 picks the source: 0 selects `src_tick_i[0]` (CPU PLL) and 1 selects `src_tick_i[1]` (auxiliary PLL).
- R5: In extended decoding, slice bits [1:0] select the source: 0 means off, 1 selects `src_tick_i[2]` (second auxiliary PLL), 2 selects `src_tick_i[0]` and 3 selects `src_tick_i[1]`.
- R6: An output period lasts D source strobes. The output is high for ceil(D/2) of them and low for the rest. `gen_tick_o` pulses for one cycle at the start of each period, and the output is high during that cycle.
- R7: A change of divisor, source or enable takes effect only at the end of the period in progress, and that period keeps its old length.
- R8: An off generator holds its output low and gives no tick. Once it is switched on, a new period starts on the next cycle, without waiting for a source strobe.
- R9: In legacy decoding the scale bit is stored but has no effect: the divisor stays (N+1)*2.
- R10: After reset both words read 0, and every output and tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | 1 | Control word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the word at addr_i |
| src_tick_i | input | 3 | Source strobes: [0] CPU PLL, [1] auxiliary PLL, [2] second auxiliary PLL |
| gen_clk_o | output | 6 | Divided outputs, one per generator |
| gen_tick_o | output | 6 | Period-start strobes, one per generator |

## Verification
The case that needs care is a register write that lands while a generator is in the middle of a period, close to the period's own wrap. The new setting must not cut that period short, and it must not be lost. The bench provokes this by timing a write a few cycles after a period start and then measuring the length of the period that contains the write; that length must be the old one. The next period is measured as well and must have the new length. The bench also writes near wraps at random as part of reconfiguration, and it measures every period by counting system cycles between ticks, so a new setting adopted on the wrong cycle shows up as a period or high time that does not match the expected value.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_AUX  = 2'd1,
    SRC_AUX2 = 2'd2
  } src_e;
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
  parameter int NUM_REG = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 1,
  parameter logic [DATA_W-1:0] KEEP_MASK = '1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_REG-1:0][DATA_W-1:0] regs_o
);
  logic [NUM_REG-1:0][DATA_W-1:0] regs_q;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (we_i && (int'(addr_i) == r)) begin
        regs_q[r] <= wdata_i & KEEP_MASK;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (int'(addr_i) == r) rdata_o = regs_q[r];
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/fgen_slice_decode.sv
module fgen_slice_decode
  import fgen_pkg::*;
#(
  parameter bit EXT_MODE = 1'b0,
  parameter int SLICE_W  = 10,
  parameter int DIV_W    = 8,
  localparam int CNT_W   = DIV_W + 1
) (
  input  logic [SLICE_W-1:0] slice_i,
  input  logic               scale_i,
  output logic               en_o,
  output src_e               src_o,
  output logic [CNT_W-1:0]   dm1_o   // divisor minus one
);
  logic [DIV_W-1:0] code;
  assign code = slice_i[2 +: DIV_W];

  if (EXT_MODE) begin : g_ext
    always_comb begin
      en_o = (slice_i[1:0] != 2'd0);
      unique case (slice_i[1:0])
        2'd1:    src_o = SRC_AUX2;
        2'd3:    src_o = SRC_AUX;
        default: src_o = SRC_CPU;
      endcase
      dm1_o = scale_i ? {1'b0, code} : {code, 1'b1};
    end
  end else begin : g_legacy
    logic unused_scale;
    assign unused_scale = scale_i;
    always_comb begin
      en_o  = slice_i[1];
      src_o = slice_i[0] ? SRC_AUX : SRC_CPU;
      dm1_o = {code, 1'b1};
    end
  end
endmodule

// File: rtl/fgen_divider.sv
module fgen_divider
  import fgen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               cfg_en_i,
  input  src_e               cfg_src_i,
  input  logic [CNT_W-1:0]   cfg_dm1_i,
  output logic               clk_o,
  output logic               tick_o
);
  logic             act_en_q, tick_q, src_hit, wrap;
  src_e             act_src_q;
  logic [CNT_W-1:0] act_dm1_q, cnt_q;

  always_comb begin
    unique case (act_src_q)
      SRC_AUX:  src_hit = src_tick_i[1];
      SRC_AUX2: src_hit = src_tick_i[2];
      default:  src_hit = src_tick_i[0];
    endcase
  end

  assign wrap = (cnt_q == act_dm1_q);

  // settings are adopted only when idle or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_q  <= 1'b0;
      act_src_q <= SRC_CPU;
      act_dm1_q <= '0;
      cnt_q     <= '0;
      tick_q    <= 1'b0;
    end else if (!act_en_q || (src_hit && wrap)) begin
      act_en_q  <= cfg_en_i;
      act_src_q <= cfg_src_i;
      act_dm1_q <= cfg_dm1_i;
      cnt_q     <= '0;
      tick_q    <= cfg_en_i;
    end else begin
      tick_q <= 1'b0;
      if (src_hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  // high for ceil(D/2) strobes
  assign clk_o  = act_en_q && (cnt_q <= (act_dm1_q >> 1));
  assign tick_o = tick_q;
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter int NUM_GEN     = 6,
  parameter int GEN_PER_REG = 3,
  parameter int SLICE_W     = 10,
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SCALE_BIT   = 30,
  parameter bit EXT_MODE    = 1'b0,
  localparam int NUM_REG    = NUM_GEN / GEN_PER_REG,
  localparam int ADDR_W     = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int CNT_W      = DIV_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic [NUM_GEN-1:0] gen_clk_o,
  output logic [NUM_GEN-1:0] gen_tick_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((64'd1 << (SCALE_BIT + 1)) - 64'd1);

  logic [NUM_REG-1:0][DATA_W-1:0] regs;

  fgen_regs #(
    .NUM_REG  (NUM_REG),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .KEEP_MASK(KEEP_MASK)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .regs_o (regs)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int RI  = g / GEN_PER_REG;
    localparam int OFF = (g % GEN_PER_REG) * SLICE_W;

    logic             cfg_en;
    src_e             cfg_src;
    logic [CNT_W-1:0] cfg_dm1;

    fgen_slice_decode #(
      .EXT_MODE(EXT_MODE),
      .SLICE_W (SLICE_W),
      .DIV_W   (DIV_W)
    ) u_dec (
      .slice_i(regs[RI][OFF +: SLICE_W]),
      .scale_i(regs[RI][SCALE_BIT]),
      .en_o   (cfg_en),
      .src_o  (cfg_src),
      .dm1_o  (cfg_dm1)
    );

    fgen_divider #(
      .CNT_W(CNT_W)
    ) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_tick_i(src_tick_i),
      .cfg_en_i  (cfg_en),
      .cfg_src_i (cfg_src),
      .cfg_dm1_i (cfg_dm1),
      .clk_o     (gen_clk_o[g]),
      .tick_o    (gen_tick_o[g])
    );
  end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
  parameter int NUM_GEN   = 6,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 1,
  parameter int SCALE_BIT = 30,
  parameter bit EXT_MODE  = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_GEN-1:0] gen_clk_o,
  input logic [NUM_GEN-1:0] gen_tick_o
);
  a_r1_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:SCALE_BIT+1] == '0);

  a_r1_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_i != $past(addr_i)) || (rdata_o[SCALE_BIT:0] == $past(wdata_i[SCALE_BIT:0])));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    a_r6_tick_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_tick_o[g] |-> gen_clk_o[g]);

    a_r7_rise_at_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gen_clk_o[g]) |-> gen_tick_o[g]);

    a_r9_no_unit_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!EXT_MODE && gen_tick_o[g]) |=> !gen_tick_o[g]);
  end
endmodule

bind fgen_bank fgen_bank_chk #(
  .NUM_GEN  (NUM_GEN),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .SCALE_BIT(SCALE_BIT),
  .EXT_MODE (EXT_MODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .gen_clk_o (gen_clk_o),
  .gen_tick_o(gen_tick_o)
);

// File: tb/fgen_bank_test.sv
module fgen_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_l = 1'b0, we_e = 1'b0;
  logic [0:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_l, rdata_e;
  logic [2:0]  src_tick = '0;
  logic [5:0]  clk_l, tick_l, clk_e, tick_e;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] sh_l [2];
  logic [31:0] sh_e [2];

  always #10 clk = ~clk;

  fgen_bank #(.EXT_MODE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_l), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_l), .src_tick_i(src_tick), .gen_clk_o(clk_l), .gen_tick_o(tick_l));

  fgen_bank #(.EXT_MODE(1'b1)) uut_ext (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_e), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_e), .src_tick_i(src_tick), .gen_clk_o(clk_e), .gen_tick_o(tick_e));

  // source strobes: CPU every cycle, AUX every 2nd, AUX2 every 3rd
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      src_tick[0] = 1'b1;
      src_tick[1] = (ph % 2 == 0);
      src_tick[2] = (ph % 3 == 0);
      ph++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit s_clk(input bit ext, input int g);
    return ext ? clk_e[g] : clk_l[g];
  endfunction

  function automatic bit s_tick(input bit ext, input int g);
    return ext ? tick_e[g] : tick_l[g];
  endfunction

  function automatic int exp_div(input bit ext, input bit scale, input int n);
    return (ext && scale) ? n + 1 : (n + 1) * 2;
  endfunction

  task automatic wr(input bit ext, input int ri, input logic [31:0] v);
    @(posedge clk); #1;
    addr = 1'(ri); wdata = v;
    if (ext) we_e = 1'b1; else we_l = 1'b1;
    @(posedge clk); #1;
    we_e = 1'b0; we_l = 1'b0;
    if (ext) sh_e[ri] = v; else sh_l[ri] = v;
  endtask

  task automatic set_slice(input bit ext, input int g, input logic [9:0] s);
    logic [31:0] v;
    int ri = g / 3;
    v = ext ? sh_e[ri] : sh_l[ri];
    v[(g % 3) * 10 +: 10] = s;
    wr(ext, ri, v);
  endtask

  task automatic set_scale(input bit ext, input int ri, input bit b);
    logic [31:0] v;
    v = ext ? sh_e[ri] : sh_l[ri];
    v[30] = b;
    wr(ext, ri, v);
  endtask

  task automatic wait_tick(input bit ext, input int g);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!s_tick(ext, g) && n < 6000);
  endtask

  // call on a sample where the tick is high
  task automatic measure(input bit ext, input int g, output int per, output int hi);
    per = 1; hi = s_clk(ext, g) ? 1 : 0;
    forever begin
      @(negedge clk);
      if (s_tick(ext, g) || per > 6000) break;
      per++;
      if (s_clk(ext, g)) hi++;
    end
  endtask

  // src: 0 cpu, 1 aux, 2 aux2
  task automatic run_gen(input bit ext, input int g, input int src, input int n,
                         input bit scale, input string req);
    logic [9:0] s;
    int d, sp, per, hi;
    if (ext) s = {8'(n), (src == 0) ? 2'd2 : (src == 1) ? 2'd3 : 2'd1};
    else     s = {8'(n), 1'b1, (src == 1)};
    set_slice(ext, g, s);
    wait_tick(ext, g);
    wait_tick(ext, g);
    measure(ext, g, per, hi);
    d  = exp_div(ext, scale, n);
    sp = src + 1;
    chk(per == d * sp, {req, " period"}, per, d * sp);
    chk(hi == ((d + 1) / 2) * sp, "R6 high time", hi, ((d + 1) / 2) * sp);
  endtask

  task automatic check_off(input bit ext, input int g, input string req);
    int hi_seen = 0, tk = 0;
    repeat (1200) @(negedge clk);
    repeat (60) begin
      @(negedge clk);
      if (s_clk(ext, g)) hi_seen++;
      if (s_tick(ext, g)) tk++;
    end
    chk(hi_seen == 0, {req, " output low"}, hi_seen, 0);
    chk(tk == 0, {req, " no tick"}, tk, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int per, hi;
    void'($urandom(32'd1234));
    sh_l[0] = '0; sh_l[1] = '0; sh_e[0] = '0; sh_e[1] = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk(clk_l == 0 && tick_l == 0 && clk_e == 0 && tick_e == 0, "R10 outputs", int'(clk_l | clk_e), 0);
    addr = 1'b0; @(negedge clk);
    chk(rdata_l == 0 && rdata_e == 0, "R10 word0", int'(rdata_l | rdata_e), 0);
    addr = 1'b1; @(negedge clk);
    chk(rdata_l == 0 && rdata_e == 0, "R10 word1", int'(rdata_l | rdata_e), 0);

    // R1 readback, enables/selects kept off
    wr(1'b0, 0, 32'hFFDF_F7FD);
    addr = 1'b0; @(negedge clk);
    chk(rdata_l == 32'h7FDF_F7FD, "R1 word0 legacy", int'(rdata_l), 32'h7FDF_F7FD);
    wr(1'b0, 1, 32'h1214_5678);
    addr = 1'b1; @(negedge clk);
    chk(rdata_l == 32'h1214_5678, "R1 word1 legacy", int'(rdata_l), 32'h1214_5678);
    wr(1'b1, 0, 32'hFFCF_F3FC);
    addr = 1'b0; @(negedge clk);
    chk(rdata_e == 32'h7FCF_F3FC, "R1 word0 ext", int'(rdata_e), 32'h7FCF_F3FC);
    chk(clk_l == 0 && clk_e == 0, "R8 disabled after writes", int'(clk_l | clk_e), 0);
    wr(1'b0, 0, 32'h0); wr(1'b0, 1, 32'h0); wr(1'b1, 0, 32'h0);

    // legacy directed
    run_gen(1'b0, 0, 0, 0, 1'b0, "R2 R4 cpu D2");
    run_gen(1'b0, 4, 1, 2, 1'b0, "R4 aux D6 word1");
    set_scale(1'b0, 0, 1'b1);
    run_gen(1'b0, 1, 0, 1, 1'b1, "R9 scale ignored");
    run_gen(1'b0, 2, 0, 255, 1'b1, "R2 max D512");
    set_scale(1'b0, 0, 1'b0);

    // extended directed
    run_gen(1'b1, 2, 1, 1, 1'b0, "R3 R5 scale clear aux");
    set_scale(1'b1, 0, 1'b1);
    run_gen(1'b1, 0, 0, 0, 1'b1, "R3 unit divisor");
    run_gen(1'b1, 1, 0, 255, 1'b1, "R3 max D256");
    set_scale(1'b1, 1, 1'b1);
    run_gen(1'b1, 5, 2, 4, 1'b1, "R5 aux2 odd D5");

    // random reconfiguration
    for (int i = 0; i < 8; i++) begin
      bit ext = 1'(i % 2);
      int g = int'($urandom_range(5, 0));
      int src = ext ? int'($urandom_range(2, 0)) : int'($urandom_range(1, 0));
      int n = int'($urandom_range(20, 0));
      bit sc = 1'b0;
      if (ext) begin
        sc = 1'($urandom_range(1, 0));
        set_scale(1'b1, g / 3, sc);
      end
      run_gen(ext, g, src, n, sc, "R2 R3 random");
    end

    // R7: write mid-period, current period keeps its length
    run_gen(1'b0, 3, 0, 9, 1'b0, "R7 setup D20");
    wait_tick(1'b0, 3);
    fork
      measure(1'b0, 3, per, hi);
      begin
        repeat (5) @(negedge clk);
        set_slice(1'b0, 3, {8'd0, 1'b1, 1'b0});
      end
    join
    chk(per == 20, "R7 old period kept", per, 20);
    measure(1'b0, 3, per, hi);
    chk(per == 2, "R7 new period", per, 2);

    // R8 disable
    set_slice(1'b0, 3, 10'd0);
    check_off(1'b0, 3, "R8 legacy off");
    set_slice(1'b1, 5, {8'd4, 2'd0});
    check_off(1'b1, 5, "R8 ext sel zero");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule